// File: doc/BRIEF.md
# Narrow-Bus Register Adapter with Byte-Order Detection

This block sits between a storage-controller sequencer and the external register bus of the controller. That bus may be one byte wide, or one 16-bit word wide with either byte order. The sequencer always sees the same interface. It asks for a 16-bit register access, a 32-bit register access or a 32-byte data-window burst, and gets back a one-cycle completion pulse with the assembled read data. The adapter turns each request into the right series of single-cycle bus strobes. On a word-wide bus it swaps byte lanes where the detected order calls for it.

After reset the adapter runs a start-up sequence before it accepts any request. It first sets the bus mode. On a word-wide bus it writes a pattern that reads the same in both byte orders and then reads it back, which tells it the device's byte order. Next it reads the version register and refuses to go ready if that register looks absent. Last, it programs the control register. Unless polling is selected, it then re-reads the control register and writes it back with both interrupt enables set.

The init sequencer has these states: `I_MODE_WR` (bus-mode write), `I_MODE_RD` (readback, word-wide only), `I_VER` (version check), `I_CTRL_WR` (control setup), `I_CTRL_RD` and `I_CTRL_SET` (interrupt read-modify-write), and then `I_READY` or `I_FAIL`. The state moves on each time the engine signals completion. The bus engine has two states, `E_IDLE` and `E_RUN`. A start moves it from `E_IDLE` to `E_RUN`. It returns to `E_IDLE` after its last bus cycle.

Top module: `busw_adapter`

## Requirements
- R1: While reset is held and during the start-up sequence, `ready` is 0 and `init_err` is 0.
- R2: With `narrow`=1, every bus strobe moves one byte on `bus_wdata[7:0]`/`bus_rdata[7:0]`, with `bus_wdata[15:8]` held at 0. A 16-bit register access is the byte at the offset followed by the byte at offset+1, low byte first. Start-up writes 0x00 to the bus-mode register at offset 0x00 with no readback, for 10 init strobes in interrupt mode.
- R3: With `narrow`=0, start-up writes 0x0101 to offset 0x00 and reads it back. A raw readback of 0x0001 selects little-endian registers (`big_endian`=0, no swap). Any other value selects big-endian registers (`big_endian`=1, the two bytes of every register word swapped). In interrupt mode there are 6 init strobes.
- R4: A 32-bit register access (`req_kind`=1) is the low 16 bits at the offset and then the high 16 bits at offset+2. That is two word strobes, or four ascending byte strobes on a byte bus.
- R5: A burst (`req_kind`=2) always uses offset 0x40 and moves 32 bytes: 32 byte strobes or 16 word strobes. Host word j holds stream byte 2j in bits 7:0 and byte 2j+1 in bits 15:8.
- R6: On a word-wide bus, burst data lanes use the byte order opposite to the register order.
- R7: Start-up reads the version register at offset 0x16. A value of 0x0000 or 0xFFFF sets `init_err` for good, and `ready` never rises. Any other value is decoded as major = bits 15:12, minor = bits 11:8, revision = bits 7:0.
- R8: Start-up writes 0x0308 to the control register at offset 0x18 (bit 3 force-config-mode, bit 8 buffer-ready interrupt enable, bit 9 error interrupt enable). With `poll_mode`=0 it then reads that register and writes it back ORed with 0x0300. With `poll_mode`=1 that read-modify-write is skipped.
- R9: A request (`req_kind` 0 = 16-bit register, 1 = 32-bit register, 2 = burst) is accepted only in a cycle with `ready`=1. Requests in other cycles are ignored. `done` pulses for one cycle, directly after the last bus strobe, with `rdata` valid. A request held in the `done` cycle is accepted at once.
- R10: During a burst write, `wtake` pulses as each host word is consumed, 16 times in all. During a burst read, `rvalid` pulses with each assembled word on `rdata[15:0]`, 16 times in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow | input | 1 | 1 = byte-wide device bus, 0 = word-wide |
| poll_mode | input | 1 | 1 = no interrupt line, skip interrupt enable step |
| req | input | 1 | Access request |
| req_kind | input | 2 | 0 reg16, 1 reg32, 2 burst |
| req_we | input | 1 | 1 = write |
| req_off | input | 7 | Register offset |
| req_wdata | input | 32 | Write value; burst words on bits 15:0 |
| ready | output | 1 | Start-up done and engine idle |
| done | output | 1 | Access complete pulse |
| rdata | output | 32 | Read result |
| rvalid | output | 1 | Burst read word valid |
| wtake | output | 1 | Burst write word consumed |
| init_err | output | 1 | Version check failed |
| big_endian | output | 1 | Detected register byte order |
| ver_major | output | 4 | Version major |
| ver_minor | output | 4 | Version minor |
| ver_rev | output | 8 | Version revision |
| bus_stb | output | 1 | Bus cycle strobe |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 7 | Bus byte address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid in the strobe cycle |

## Verification
The completion pulse of one access and the acceptance of the next one can fall in the same cycle, because the engine is already idle while `done` is high. The bench raises a 32-bit write and keeps `req` high with new fields through the whole access. That held request must be ignored while the engine is busy, and then taken in the `done` cycle. The result is judged by the device's stored bytes, by exactly two completion pulses, and by a total of three word strobes with nothing left over.

// File: rtl/busw_pkg.sv
package busw_pkg;
    typedef enum logic [1:0] {
        K_REG16 = 2'd0,
        K_REG32 = 2'd1,
        K_BURST = 2'd2
    } kind_e;

    localparam logic [6:0]  OFF_MODE    = 7'h00;
    localparam logic [6:0]  OFF_VER     = 7'h16;
    localparam logic [6:0]  OFF_CTRL    = 7'h18;
    localparam logic [15:0] MODE_PROBE  = 16'h0101;
    localparam logic [15:0] MODE_LE     = 16'h0001;
    localparam logic [15:0] CTRL_SETUP  = 16'h0308;
    localparam logic [15:0] CTRL_IRQS   = 16'h0300;

    function automatic logic [15:0] swap16(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction
endpackage

// File: rtl/busw_engine.sv
module busw_engine
    import busw_pkg::*;
#(
    parameter int AW          = 7,
    parameter int WIN         = 'h40,
    parameter int BURST_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          narrow,
    input  logic          rswap,
    input  logic          dswap,
    input  logic          start,
    input  kind_e         kind,
    input  logic          we,
    input  logic [AW-1:0] off,
    input  logic [31:0]   wdata,
    output logic          busy,
    output logic          done,
    output logic [31:0]   rdata,
    output logic          rvalid,
    output logic          wtake,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata
);
    localparam int CW          = $clog2(BURST_BYTES);
    localparam int BURST_WORDS = BURST_BYTES / 2;

    typedef enum logic {E_IDLE, E_RUN} est_e;

    est_e          st;
    logic [CW-1:0] cyc, last;
    kind_e         k_q;
    logic          we_q, done_q, rvalid_q;
    logic [AW-1:0] off_q;
    logic [31:0]   wd_q, rd_q;
    logic          run, word_end;

    function automatic logic [CW-1:0] last_of(input kind_e k, input logic n);
        unique case (k)
            K_REG32: return n ? CW'(3) : CW'(1);
            K_BURST: return n ? CW'(BURST_BYTES - 1) : CW'(BURST_WORDS - 1);
            default: return n ? CW'(1) : CW'(0);
        endcase
    endfunction

    assign run      = (st == E_RUN);
    assign word_end = narrow ? cyc[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= E_IDLE;
            cyc <= '0;
            last <= '0;
            k_q <= K_REG16;
            we_q <= 1'b0;
            off_q <= '0;
            wd_q <= '0;
            done_q <= 1'b0;
            rvalid_q <= 1'b0;
            rd_q <= '0;
        end else begin
            done_q   <= run && (cyc == last);
            rvalid_q <= run && !we_q && (k_q == K_BURST) && word_end;
            unique case (st)
                E_IDLE: if (start) begin
                    st    <= E_RUN;
                    cyc   <= '0;
                    last  <= last_of(kind, narrow);
                    k_q   <= kind;
                    we_q  <= we;
                    off_q <= off;
                    wd_q  <= wdata;
                    rd_q  <= '0;
                end
                E_RUN: begin
                    cyc <= cyc + 1'b1;
                    if (cyc == last) st <= E_IDLE;
                    if (!we_q) begin
                        if (narrow && k_q == K_BURST) begin
                            if (cyc[0]) rd_q[15:8] <= bus_rdata[7:0];
                            else        rd_q[7:0]  <= bus_rdata[7:0];
                        end else if (narrow) begin
                            rd_q[{cyc[1:0], 3'b000} +: 8] <= bus_rdata[7:0];
                        end else if (k_q == K_BURST) begin
                            rd_q[15:0] <= dswap ? swap16(bus_rdata) : bus_rdata;
                        end else begin
                            rd_q[{cyc[0], 4'b0000} +: 16] <= rswap ? swap16(bus_rdata) : bus_rdata;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        bus_stb   = run;
        bus_we    = we_q;
        wtake     = run && we_q && (k_q == K_BURST) && word_end;
        bus_wdata = 16'h0000;
        if (k_q == K_BURST) begin
            bus_addr = AW'(WIN);
            if (narrow) bus_wdata = {8'h00, cyc[0] ? wdata[15:8] : wdata[7:0]};
            else        bus_wdata = dswap ? swap16(wdata[15:0]) : wdata[15:0];
        end else if (narrow) begin
            bus_addr  = off_q + AW'(cyc);
            bus_wdata = {8'h00, wd_q[{cyc[1:0], 3'b000} +: 8]};
        end else begin
            bus_addr  = off_q + AW'({cyc, 1'b0});
            bus_wdata = rswap ? swap16(wd_q[{cyc[0], 4'b0000} +: 16])
                              : wd_q[{cyc[0], 4'b0000} +: 16];
        end
    end

    assign busy   = run;
    assign done   = done_q;
    assign rdata  = rd_q;
    assign rvalid = rvalid_q;
endmodule

// File: rtl/busw_init.sv
module busw_init
    import busw_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          narrow,
    input  logic          poll_mode,
    input  logic          eng_done,
    input  logic [15:0]   eng_rdata,
    output logic          start,
    output logic          we,
    output logic [AW-1:0] off,
    output logic [31:0]   wdata,
    output logic          be,
    output logic          is_ready,
    output logic          is_fail,
    output logic [15:0]   version
);
    typedef enum logic [2:0] {
        I_MODE_WR, I_MODE_RD, I_VER, I_CTRL_WR,
        I_CTRL_RD, I_CTRL_SET, I_READY, I_FAIL
    } ist_e;

    ist_e        st, nxt;
    logic        issued;
    logic [15:0] ctrl_q;
    logic        ver_bad;

    assign ver_bad = (eng_rdata == 16'h0000) || (eng_rdata == 16'hFFFF);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= I_MODE_WR;
            issued  <= 1'b0;
            be      <= 1'b0;
            ctrl_q  <= '0;
            version <= '0;
        end else begin
            st <= nxt;
            if (eng_done)   issued <= 1'b0;
            else if (start) issued <= 1'b1;
            if (eng_done && st == I_MODE_RD) be      <= (eng_rdata != MODE_LE);
            if (eng_done && st == I_VER)     version <= eng_rdata;
            if (eng_done && st == I_CTRL_RD) ctrl_q  <= eng_rdata;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            I_MODE_WR:  if (eng_done) nxt = narrow ? I_VER : I_MODE_RD;
            I_MODE_RD:  if (eng_done) nxt = I_VER;
            I_VER:      if (eng_done) nxt = ver_bad ? I_FAIL : I_CTRL_WR;
            I_CTRL_WR:  if (eng_done) nxt = poll_mode ? I_READY : I_CTRL_RD;
            I_CTRL_RD:  if (eng_done) nxt = I_CTRL_SET;
            I_CTRL_SET: if (eng_done) nxt = I_READY;
            I_READY:    nxt = I_READY;
            I_FAIL:     nxt = I_FAIL;
        endcase
    end

    always_comb begin
        we    = 1'b0;
        off   = AW'(OFF_MODE);
        wdata = 32'h0;
        unique case (st)
            I_MODE_WR:  begin we = 1'b1; wdata = narrow ? 32'h0 : {16'h0, MODE_PROBE}; end
            I_MODE_RD:  off = AW'(OFF_MODE);
            I_VER:      off = AW'(OFF_VER);
            I_CTRL_WR:  begin we = 1'b1; off = AW'(OFF_CTRL); wdata = {16'h0, CTRL_SETUP}; end
            I_CTRL_RD:  off = AW'(OFF_CTRL);
            I_CTRL_SET: begin we = 1'b1; off = AW'(OFF_CTRL); wdata = {16'h0, ctrl_q | CTRL_IRQS}; end
            default:    ;
        endcase
        start    = !issued && (st != I_READY) && (st != I_FAIL);
        is_ready = (st == I_READY);
        is_fail  = (st == I_FAIL);
    end
endmodule

// File: rtl/busw_adapter.sv
module busw_adapter
    import busw_pkg::*;
#(
    parameter int AW          = 7,
    parameter int WIN         = 'h40,
    parameter int BURST_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          narrow,
    input  logic          poll_mode,
    input  logic          req,
    input  logic [1:0]    req_kind,
    input  logic          req_we,
    input  logic [AW-1:0] req_off,
    input  logic [31:0]   req_wdata,
    output logic          ready,
    output logic          done,
    output logic [31:0]   rdata,
    output logic          rvalid,
    output logic          wtake,
    output logic          init_err,
    output logic          big_endian,
    output logic [3:0]    ver_major,
    output logic [3:0]    ver_minor,
    output logic [7:0]    ver_rev,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata
);
    logic          eng_busy, eng_done, eng_start, eng_we;
    logic [31:0]   eng_rdata, eng_wdata;
    logic [AW-1:0] eng_off;
    kind_e         eng_kind;
    logic          i_start, i_we, i_ready, i_fail, i_be;
    logic [AW-1:0] i_off;
    logic [31:0]   i_wdata;
    logic [15:0]   i_ver;

    busw_init #(.AW(AW)) u_init (
        .clk(clk), .rst_n(rst_n), .narrow(narrow), .poll_mode(poll_mode),
        .eng_done(eng_done), .eng_rdata(eng_rdata[15:0]),
        .start(i_start), .we(i_we), .off(i_off), .wdata(i_wdata),
        .be(i_be), .is_ready(i_ready), .is_fail(i_fail), .version(i_ver)
    );

    always_comb begin
        if (i_ready) begin
            eng_start = req && !eng_busy;
            eng_kind  = kind_e'(req_kind);
            eng_we    = req_we;
            eng_off   = req_off;
            eng_wdata = req_wdata;
        end else begin
            eng_start = i_start;
            eng_kind  = K_REG16;
            eng_we    = i_we;
            eng_off   = i_off;
            eng_wdata = i_wdata;
        end
    end

    busw_engine #(.AW(AW), .WIN(WIN), .BURST_BYTES(BURST_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .narrow(narrow), .rswap(i_be), .dswap(!i_be),
        .start(eng_start), .kind(eng_kind), .we(eng_we), .off(eng_off),
        .wdata(eng_wdata), .busy(eng_busy), .done(eng_done), .rdata(eng_rdata),
        .rvalid(rvalid), .wtake(wtake), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    assign ready      = i_ready && !eng_busy;
    assign done       = i_ready && eng_done;
    assign rdata      = eng_rdata;
    assign init_err   = i_fail;
    assign big_endian = i_be;
    assign ver_major  = i_ver[15:12];
    assign ver_minor  = i_ver[11:8];
    assign ver_rev    = i_ver[7:0];
endmodule

// File: rtl/busw_checker.sv
module busw_checker #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          narrow,
    input logic          ready,
    input logic          done,
    input logic          rvalid,
    input logic          wtake,
    input logic          init_err,
    input logic          big_endian,
    input logic          bus_stb,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_wdata
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_stb) && !bus_stb));
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> (init_err && !ready));
    a_r3_order_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(big_endian));
    a_r2_upper_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && bus_stb && bus_we) |-> (bus_wdata[15:8] == 8'h00));
    a_r5_window_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wtake |-> (bus_stb && bus_we && bus_addr == AW'('h40)));
    a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($past(bus_stb) && !$past(bus_we)));
endmodule

bind busw_adapter busw_checker #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .ready(ready), .done(done),
    .rvalid(rvalid), .wtake(wtake), .init_err(init_err), .big_endian(big_endian),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_busw_adapter.sv
`timescale 1ns/1ps
module test_busw_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow = 1'b0, poll_mode = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [6:0]  req_off = 7'h0;
    logic [31:0] req_wdata, reg_wd = 32'h0;
    logic        ready, done, rvalid, wtake, init_err, big_endian;
    logic [31:0] rdata;
    logic [3:0]  ver_major, ver_minor;
    logic [7:0]  ver_rev;
    logic        bus_stb, bus_we;
    logic [6:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    logic        dev_be = 1'b0;
    logic        bmode = 1'b0;
    logic [7:0]  mem [128];
    logic [7:0]  wlog [64];
    int          rd_ptr, wr_ptr, ncyc, nctrl, bw_idx;
    int          n_checks = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    busw_adapter i_busw_adapter (
        .clk(clk), .rst_n(rst_n), .narrow(narrow), .poll_mode(poll_mode),
        .req(req), .req_kind(req_kind), .req_we(req_we), .req_off(req_off),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
        .rvalid(rvalid), .wtake(wtake), .init_err(init_err), .big_endian(big_endian),
        .ver_major(ver_major), .ver_minor(ver_minor), .ver_rev(ver_rev),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] fbyte(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction
    function automatic logic [15:0] bpat(input int j);
        return {8'(j) ^ 8'h5A, 8'(j) + 8'h30};
    endfunction

    assign req_wdata = bmode ? {16'h0, bpat(bw_idx)} : reg_wd;

    // device model: byte-addressed registers, data window at 0x40
    always_comb begin
        bus_rdata = 16'h0;
        if (narrow) begin
            bus_rdata = (bus_addr == 7'h40) ? {8'h0, fbyte(rd_ptr)} : {8'h0, mem[bus_addr]};
        end else if (bus_addr == 7'h40) begin
            bus_rdata = dev_be ? {fbyte(rd_ptr + 1), fbyte(rd_ptr)} : {fbyte(rd_ptr), fbyte(rd_ptr + 1)};
        end else begin
            bus_rdata = dev_be ? {mem[bus_addr], mem[bus_addr + 7'd1]} : {mem[bus_addr + 7'd1], mem[bus_addr]};
        end
    end

    always @(posedge clk) begin
        if (req) bw_idx <= 0;
        else if (wtake) bw_idx <= bw_idx + 1;
        if (bus_stb) begin
            ncyc <= ncyc + 1;
            if (bus_we && bus_addr == 7'h18) nctrl <= nctrl + 1;
            if (narrow) begin
                if (bus_addr == 7'h40) begin
                    if (bus_we) begin wlog[wr_ptr] <= bus_wdata[7:0]; wr_ptr <= wr_ptr + 1; end
                    else rd_ptr <= rd_ptr + 1;
                end else if (bus_we) mem[bus_addr] <= bus_wdata[7:0];
            end else if (bus_addr == 7'h40) begin
                if (bus_we) begin
                    wlog[wr_ptr]     <= dev_be ? bus_wdata[7:0]  : bus_wdata[15:8];
                    wlog[wr_ptr + 1] <= dev_be ? bus_wdata[15:8] : bus_wdata[7:0];
                    wr_ptr <= wr_ptr + 2;
                end else rd_ptr <= rd_ptr + 2;
            end else if (bus_we) begin
                mem[bus_addr]        <= dev_be ? bus_wdata[15:8] : bus_wdata[7:0];
                mem[bus_addr + 7'd1] <= (bus_addr == 7'h00) ? 8'h00 :
                                        (dev_be ? bus_wdata[7:0] : bus_wdata[15:8]);
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic boot(input logic n, input logic b, input logic p, input logic [15:0] ver);
        rst_n = 1'b0;
        narrow = n; dev_be = b; poll_mode = p; req = 1'b0; bmode = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'hA5;
        mem[1] = 8'hFF; mem[0] = 8'hFF;
        mem[7'h16] = ver[7:0]; mem[7'h17] = ver[15:8];
        mem[7'h18] = 8'h00; mem[7'h19] = 8'h00;
        rd_ptr = 0; wr_ptr = 0; ncyc = 0; nctrl = 0;
        repeat (2) @(negedge clk);
        chk(!ready && !init_err, "R1 in reset", {ready, init_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ready && !init_err, "R1 init running", {ready, init_err}, 0);
        for (int i = 0; i < 100 && !ready && !init_err; i++) @(negedge clk);
    endtask

    task automatic host_op(input logic [1:0] k, input logic w, input logic [6:0] o,
                           input logic [31:0] wd, output logic [31:0] rd, output int nstb,
                           output int nbeat, input string rq);
        bit prev = 1'b0;
        nstb = 0; nbeat = 0; rd = '0;
        while (!ready) @(negedge clk);
        ncyc = 0; nctrl = 0;
        req_kind = k; req_we = w; req_off = o; reg_wd = wd;
        bmode = (k == 2'd2) && w;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (bus_stb) nstb++;
            if (rvalid) begin
                chk(rdata[15:0] == {fbyte(2 * nbeat + 1), fbyte(2 * nbeat)}, {rq, " R5 R6 read word"},
                    rdata[15:0], {fbyte(2 * nbeat + 1), fbyte(2 * nbeat)});
                nbeat++;
            end
            if (wtake) nbeat++;
            if (done) break;
            prev = bus_stb;
            @(negedge clk);
        end
        chk(done && prev && !bus_stb, {rq, " R9 done after last strobe"}, {done, prev, bus_stb}, 3'b110);
        rd = rdata;
        bmode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_init_le();
        boot(1'b0, 1'b0, 1'b0, 16'h2315);
        chk(ready, "R1 ready after init", ready, 1);
        chk(big_endian == 1'b0, "R3 little-endian detect", big_endian, 0);
        chk({ver_major, ver_minor, ver_rev} == 16'h2315, "R7 version fields",
            {ver_major, ver_minor, ver_rev}, 16'h2315);
        chk(ncyc == 6, "R3 init strobes word bus", ncyc, 6);
        chk(nctrl == 2, "R8 ctrl written twice", nctrl, 2);
        chk({mem[7'h19], mem[7'h18]} == 16'h0308, "R8 ctrl value", {mem[7'h19], mem[7'h18]}, 16'h0308);
    endtask

    task automatic t_init_be();
        boot(1'b0, 1'b1, 1'b0, 16'hA7C2);
        chk(big_endian == 1'b1, "R3 big-endian detect", big_endian, 1);
        chk({ver_major, ver_minor, ver_rev} == 16'hA7C2, "R7 version swapped", {ver_major, ver_minor, ver_rev}, 16'hA7C2);
        chk({mem[7'h19], mem[7'h18]} == 16'h0308, "R8 ctrl value be", {mem[7'h19], mem[7'h18]}, 16'h0308);
    endtask

    task automatic t_init_narrow();
        boot(1'b1, 1'b0, 1'b0, 16'h1203);
        chk({mem[1], mem[0]} == 16'h0000, "R2 bus mode bytes", {mem[1], mem[0]}, 0);
        chk(ncyc == 10, "R2 init strobes byte bus", ncyc, 10);
        chk({ver_major, ver_minor, ver_rev} == 16'h1203, "R7 version byte bus", {ver_major, ver_minor, ver_rev}, 16'h1203);
        chk({mem[7'h19], mem[7'h18]} == 16'h0308, "R8 ctrl byte bus", {mem[7'h19], mem[7'h18]}, 16'h0308);
    endtask

    task automatic t_bad_version();
        boot(1'b0, 1'b0, 1'b0, 16'hFFFF);
        repeat (20) @(negedge clk);
        chk(init_err && !ready, "R7 version FFFF", {init_err, ready}, 2'b10);
        boot(1'b1, 1'b0, 1'b0, 16'h0000);
        repeat (20) @(negedge clk);
        chk(init_err && !ready, "R7 version 0000", {init_err, ready}, 2'b10);
    endtask

    task automatic t_poll();
        boot(1'b0, 1'b0, 1'b1, 16'h1111);
        chk(ready && nctrl == 1, "R8 poll skips rmw", nctrl, 1);
        chk(ncyc == 4, "R8 poll strobes", ncyc, 4);
    endtask

    task automatic t_regs(input logic n, input logic b, input string tag);
        logic [31:0] rd;
        int ns, nb;
        boot(n, b, 1'b0, 16'h4321);
        host_op(2'd1, 1'b1, 7'h20, 32'hDEADBEEF, rd, ns, nb, tag);
        chk({mem[7'h23], mem[7'h22], mem[7'h21], mem[7'h20]} == 32'hDEADBEEF, {tag, " R4 reg32 write"},
            {mem[7'h23], mem[7'h22], mem[7'h21], mem[7'h20]}, 32'hDEADBEEF);
        chk(ns == (n ? 4 : 2), {tag, " R4 reg32 strobes"}, ns, n ? 4 : 2);
        host_op(2'd1, 1'b0, 7'h20, 32'h0, rd, ns, nb, tag);
        chk(rd == 32'hDEADBEEF, {tag, " R4 reg32 read"}, rd, 32'hDEADBEEF);
        host_op(2'd0, 1'b0, 7'h16, 32'h0, rd, ns, nb, tag);
        chk(rd == 32'h4321 && ns == (n ? 2 : 1), {tag, " R2 R3 reg16 read"}, rd, 32'h4321);
        host_op(2'd0, 1'b1, 7'h30, 32'h1234, rd, ns, nb, tag);
        chk({mem[7'h31], mem[7'h30]} == 16'h1234, {tag, " R2 R3 reg16 write"}, {mem[7'h31], mem[7'h30]}, 16'h1234);
    endtask

    task automatic t_burst(input logic n, input logic b, input string tag);
        logic [31:0] rd;
        int ns, nb;
        bit ok = 1'b1;
        boot(n, b, 1'b0, 16'h0102);
        host_op(2'd2, 1'b0, 7'h00, 32'h0, rd, ns, nb, tag);
        chk(ns == (n ? 32 : 16), {tag, " R5 burst read strobes"}, ns, n ? 32 : 16);
        chk(nb == 16, {tag, " R10 rvalid count"}, nb, 16);
        host_op(2'd2, 1'b1, 7'h00, 32'h0, rd, ns, nb, tag);
        chk(nb == 16 && ns == (n ? 32 : 16), {tag, " R10 wtake count"}, nb, 16);
        for (int j = 0; j < 16; j++)
            if ({wlog[2 * j + 1], wlog[2 * j]} != bpat(j)) ok = 1'b0;
        chk(ok, {tag, " R5 R6 burst write bytes"}, {wlog[1], wlog[0]}, bpat(0));
    endtask

    task automatic t_back_to_back();
        int dones = 0;
        boot(1'b0, 1'b0, 1'b0, 16'h0102);
        while (!ready) @(negedge clk);
        ncyc = 0;
        mem[7'h2C] = 8'h00; mem[7'h2D] = 8'h00;
        req_kind = 2'd1; req_we = 1'b1; req_off = 7'h24; reg_wd = 32'h11223344; req = 1'b1;
        @(negedge clk);
        req_kind = 2'd0; req_off = 7'h2C; reg_wd = 32'h0000ABCD;
        for (int i = 0; i < 20; i++) begin
            if (done) begin
                dones++;
                if (dones == 1) begin @(negedge clk); req = 1'b0; continue; end
            end
            @(negedge clk);
        end
        req = 1'b0;
        chk(dones == 2, "R9 two completions", dones, 2);
        chk(ncyc == 3, "R9 busy request ignored", ncyc, 3);
        chk({mem[7'h27], mem[7'h26], mem[7'h25], mem[7'h24]} == 32'h11223344, "R9 first op",
            {mem[7'h27], mem[7'h26], mem[7'h25], mem[7'h24]}, 32'h11223344);
        chk({mem[7'h2D], mem[7'h2C]} == 16'hABCD, "R9 op accepted in done cycle", {mem[7'h2D], mem[7'h2C]}, 16'hABCD);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_init_le();
        t_init_be();
        t_init_narrow();
        t_bad_version();
        t_poll();
        t_regs(1'b0, 1'b0, "word-le");
        t_regs(1'b0, 1'b1, "word-be");
        t_regs(1'b1, 1'b0, "byte");
        t_burst(1'b0, 1'b0, "word-le");
        t_burst(1'b0, 1'b1, "word-be");
        t_burst(1'b1, 1'b0, "byte");
        t_back_to_back();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule